// File: doc/BRIEF.md
# Per-Input Circular Page Recorder

This block manages one signal input's share of a large page-organised sample memory. Software gives it a region, as a first page and a page count. The block then turns that region into a circular buffer. Packed pages arrive as a stream of beats, and the final beat carries an end-of-page marker and the page's 64-bit sample sequence number. For every beat it accepts, the block drives a write enable and the absolute page address. On the end-of-page beat it commits the page. Committing advances the write position, which wraps back to the first page after the last page of the region.

The block has two states, recording and stopped (frozen), and leaves reset in the stopped state. While it is stopped, incoming pages are dropped and the allocation may be changed. When recording restarts after a new allocation, the buffer begins again at the first page and the fresh-page count is cleared. When recording resumes with an unchanged allocation, writing continues at the page after the last committed one, and old contents are overwritten rather than cleared.

The block reports the index and sequence number of the last committed page. It also reports how many fresh pages the region holds; this count saturates at the region size, which marks a full buffer of fresh data. A region of zero pages means the input has no buffer, so nothing is ever written.

Top module: `page_recorder`

## Requirements
- R1: After reset the block is stopped: `isRecording`=0, `wrEn`=0, `freshPages`=0, `lastPage`=0 and `lastSsn`=0.
- R2: `isRecording` goes to 1 on the first clock edge at which `recordEn` is 1, and back to 0 on the first edge at which `recordEn` is 0.
- R3: While recording, each accepted beat gives `wrEn`=1 in the same cycle, with `wrPage` = (first page + write offset) mod 2^PAGE_AW. While stopped, `wrEn` is 0.
- R4: A page is committed when its beat with `pageEnd`=1 is accepted. The write offset then steps by one and returns to 0 after the page at offset count-1.
- R5: `freshPages` rises by one on each commit and saturates at the region's page count.
- R6: On a commit, `lastPage` takes the committed page's `wrPage` and `lastSsn` takes `pageSsn` from the end beat. Both are visible from the next clock edge.
- R7: With a page count of 0, no beat raises `wrEn` and no page is committed.
- R8: An allocation write (`allocWe`=1) is accepted only while stopped. A write made while recording changes neither the region nor the write position.
- R9: Entering recording after an accepted allocation write resets the write offset and `freshPages` to 0. Entering recording without one continues at the next page and keeps `freshPages`.
- R10: A page is written and committed only if recording was active at its first beat and stayed active through its end beat. A page cut short by a freeze is not committed, and its page index is reused by the next page.
- R11: Page addresses wrap at 2^PAGE_AW. A region that starts near the top of memory continues at page 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| recordEn | input | 1 | 1 requests recording, 0 requests freeze |
| allocWe | input | 1 | Allocation write strobe |
| allocFirst | input | PAGE_AW | First page of the region |
| allocCount | input | PAGE_AW+1 | Number of pages in the region (0 = no buffer) |
| pageBeat | input | 1 | A word of the current page is present |
| pageEnd | input | 1 | The present word is the last of its page |
| pageSsn | input | SSN_W | Sequence number of the page, valid with pageEnd |
| wrEn | output | 1 | Write enable for the present word |
| wrPage | output | PAGE_AW | Absolute page address for the write |
| isRecording | output | 1 | 1 while in the recording state |
| lastPage | output | PAGE_AW | Page index of the last committed page |
| lastSsn | output | SSN_W | Sequence number of the last committed page |
| freshPages | output | PAGE_AW+1 | Number of fresh pages held, saturating at the page count |

## Verification
A wrong write offset shows on `wrPage` at the first beat of the next page. The same offset is copied into `lastPage` one edge after that page's end beat, so the error is also visible there. A fault in the saturation of the fresh counter only appears once more pages than the region holds have been recorded, so the page sequence runs past the wrap. A mistake in the mid-page freeze flag, or in the flag that marks a new allocation, stays hidden until the next recording starts or the next end beat arrives. It then shows as a page index that was skipped or not reused, or as a counter that was not cleared.

// File: rtl/page_recorder_pkg.sv
package page_recorder_pkg;
  typedef struct packed {
    logic allocLoad;  // latch a new region
    logic restart;    // clear offset and fresh count
    logic commit;     // a page finished
    logic rec;        // recording state
  } recStrobe_t;
endpackage

// File: rtl/page_recorder_ctrl.sv
module page_recorder_ctrl
  import page_recorder_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       recordEn,
  input  logic       allocWe,
  input  logic       pageBeat,
  input  logic       pageEnd,
  input  logic       allocZero,
  output logic       wrEn,
  output logic       isRecording,
  output recStrobe_t strobe
);
  typedef enum logic [1:0] {ST_RST, ST_STOP, ST_REC} recState_t;
  recState_t state;
  logic allocDirty;
  logic midPage;
  logic pageGood;
  logic goodNow;
  logic rec;

  assign rec = (state == ST_REC);
  assign isRecording = rec;
  assign goodNow = (midPage ? pageGood : 1'b1) && rec;
  assign wrEn = pageBeat && goodNow && !allocZero;

  always_comb begin
    strobe.rec       = rec;
    strobe.allocLoad = allocWe && (state == ST_STOP);
    strobe.restart   = (state == ST_STOP) && recordEn && (allocDirty || strobe.allocLoad);
    strobe.commit    = wrEn && pageEnd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_RST;
      allocDirty <= 1'b1;
      midPage    <= 1'b0;
      pageGood   <= 1'b0;
    end else begin
      case (state)
        ST_RST:  state <= ST_STOP;
        ST_STOP: if (recordEn) state <= ST_REC;
        ST_REC:  if (!recordEn) state <= ST_STOP;
        default: state <= ST_STOP;
      endcase
      if (strobe.restart) allocDirty <= 1'b0;
      else if (strobe.allocLoad) allocDirty <= 1'b1;
      if (pageBeat) begin
        midPage  <= !pageEnd;
        pageGood <= goodNow && !pageEnd;
      end else if (midPage) begin
        pageGood <= pageGood && rec;
      end
    end
  end

  // R2: a freeze request always leaves the recording state on the next edge
  p_freeze_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rec && !recordEn) |=> !isRecording);
endmodule

// File: rtl/page_recorder_dp.sv
module page_recorder_dp
  import page_recorder_pkg::*;
#(
  parameter int PAGE_AW = 21,
  parameter int SSN_W   = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  recStrobe_t           strobe,
  input  logic [PAGE_AW-1:0]   allocFirst,
  input  logic [PAGE_AW:0]     allocCount,
  input  logic [SSN_W-1:0]     pageSsn,
  output logic                 allocZero,
  output logic [PAGE_AW-1:0]   wrPage,
  output logic [PAGE_AW-1:0]   lastPage,
  output logic [SSN_W-1:0]     lastSsn,
  output logic [PAGE_AW:0]     freshPages
);
  localparam int CW = PAGE_AW + 1;

  logic [PAGE_AW-1:0] regFirst;
  logic [CW-1:0]      regCount;
  logic [CW-1:0]      offset;
  logic [CW-1:0]      offsetInc;

  assign allocZero = (regCount == '0);
  assign offsetInc = offset + CW'(1);
  assign wrPage    = regFirst + offset[PAGE_AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regFirst   <= '0;
      regCount   <= '0;
      offset     <= '0;
      freshPages <= '0;
      lastPage   <= '0;
      lastSsn    <= '0;
    end else begin
      if (strobe.allocLoad) begin
        regFirst <= allocFirst;
        regCount <= allocCount;
      end
      if (strobe.restart) begin
        offset     <= '0;
        freshPages <= '0;
      end else if (strobe.commit) begin
        offset     <= (offsetInc >= regCount) ? '0 : offsetInc;
        freshPages <= (freshPages >= regCount) ? regCount : freshPages + CW'(1);
        lastPage   <= wrPage;
        lastSsn    <= pageSsn;
      end
    end
  end

  p_offset_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.rec && !allocZero) |-> (offset < regCount));
  p_fresh_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.rec |-> (freshPages <= regCount));
  p_last_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.commit |=> (lastPage == $past(wrPage)));
  p_commit_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.commit |-> !allocZero);
  p_alloc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.rec |=> ($stable(regFirst) && $stable(regCount)));
endmodule

// File: rtl/page_recorder.sv
module page_recorder
  import page_recorder_pkg::*;
#(
  parameter int PAGE_AW = 21,
  parameter int SSN_W   = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               recordEn,
  input  logic               allocWe,
  input  logic [PAGE_AW-1:0] allocFirst,
  input  logic [PAGE_AW:0]   allocCount,
  input  logic               pageBeat,
  input  logic               pageEnd,
  input  logic [SSN_W-1:0]   pageSsn,
  output logic               wrEn,
  output logic [PAGE_AW-1:0] wrPage,
  output logic               isRecording,
  output logic [PAGE_AW-1:0] lastPage,
  output logic [SSN_W-1:0]   lastSsn,
  output logic [PAGE_AW:0]   freshPages
);
  recStrobe_t strobe;
  logic       allocZero;

  page_recorder_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .recordEn(recordEn), .allocWe(allocWe),
    .pageBeat(pageBeat), .pageEnd(pageEnd), .allocZero(allocZero),
    .wrEn(wrEn), .isRecording(isRecording), .strobe(strobe)
  );

  page_recorder_dp #(.PAGE_AW(PAGE_AW), .SSN_W(SSN_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .allocFirst(allocFirst), .allocCount(allocCount), .pageSsn(pageSsn),
    .allocZero(allocZero), .wrPage(wrPage), .lastPage(lastPage),
    .lastSsn(lastSsn), .freshPages(freshPages)
  );
endmodule

// File: tb/tb_page_recorder.sv
module tb_page_recorder;
  localparam int PAGE_AW = 21;
  localparam int SSN_W   = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic recordEn = 1'b0;
  logic allocWe = 1'b0;
  logic [PAGE_AW-1:0] allocFirst = '0;
  logic [PAGE_AW:0]   allocCount = '0;
  logic pageBeat = 1'b0;
  logic pageEnd = 1'b0;
  logic [SSN_W-1:0] pageSsn = '0;
  logic wrEn;
  logic [PAGE_AW-1:0] wrPage;
  logic isRecording;
  logic [PAGE_AW-1:0] lastPage;
  logic [SSN_W-1:0] lastSsn;
  logic [PAGE_AW:0] freshPages;

  int nChecks = 0;
  int nErrors = 0;
  logic done = 1'b0;

  page_recorder #(.PAGE_AW(PAGE_AW), .SSN_W(SSN_W)) dut (.*);

  always #5 clk = ~clk;

  // table: expected page address and fresh count after each page
  localparam int NV = 5;
  localparam logic [PAGE_AW-1:0] V_ADDR [NV] = '{21'd10, 21'd11, 21'd12, 21'd10, 21'd11};
  localparam logic [PAGE_AW:0]   V_FRESH[NV] = '{22'd1, 22'd2, 22'd3, 22'd3, 22'd3};

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setRec(logic v);
    @(negedge clk); recordEn = v;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic writeAlloc(int first, int count);
    @(negedge clk);
    allocWe = 1'b1; allocFirst = PAGE_AW'(first); allocCount = (PAGE_AW+1)'(count);
    @(negedge clk); allocWe = 1'b0;
  endtask

  // send a page of n beats; check write enable/address on each beat
  task automatic sendPage(int n, logic [63:0] ssn, logic expWr, int expAddr, string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pageBeat = 1'b1; pageEnd = (i == n - 1); pageSsn = ssn;
      #1;
      check(req, {63'd0, wrEn}, {63'd0, expWr});
      if (expWr) check(req, 64'(wrPage), 64'(expAddr));
    end
    @(negedge clk); pageBeat = 1'b0; pageEnd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nErrors++; nChecks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", {63'd0, isRecording}, 64'd0);
    check("R1", {63'd0, wrEn}, 64'd0);
    check("R1", 64'(freshPages), 64'd0);
    check("R1", 64'(lastPage), 64'd0);
    check("R1", lastSsn, 64'd0);

    // R3 stopped: no write
    sendPage(2, 64'd7, 1'b0, 0, "R3");

    writeAlloc(10, 3);
    setRec(1'b1);
    check("R2", {63'd0, isRecording}, 64'd1);

    // table walk: R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      sendPage(3, 64'(1000 + v), 1'b1, int'(V_ADDR[v]), "R3/R4");
      check("R5", 64'(freshPages), 64'(V_FRESH[v]));
      check("R6", 64'(lastPage), 64'(V_ADDR[v]));
      check("R6", lastSsn, 64'(1000 + v));
    end

    // R8 allocation write while recording ignored
    writeAlloc(500, 7);
    sendPage(2, 64'd2000, 1'b1, 12, "R8");
    check("R8", 64'(freshPages), 64'd3);

    // R9 resume with same allocation continues
    setRec(1'b0);
    check("R2", {63'd0, isRecording}, 64'd0);
    setRec(1'b1);
    sendPage(2, 64'd2001, 1'b1, 10, "R9");
    check("R9", 64'(freshPages), 64'd3);

    // R10 freeze mid-page
    @(negedge clk); pageBeat = 1'b1; pageEnd = 1'b0; #1;
    check("R10", {63'd0, wrEn}, 64'd1);
    check("R10", 64'(wrPage), 64'd11);
    @(negedge clk); pageBeat = 1'b0;
    setRec(1'b0);
    setRec(1'b1);
    @(negedge clk); pageBeat = 1'b1; pageEnd = 1'b1; #1;
    check("R10", {63'd0, wrEn}, 64'd0);
    @(negedge clk); pageBeat = 1'b0; pageEnd = 1'b0;
    check("R10", 64'(lastPage), 64'd10);
    sendPage(2, 64'd2002, 1'b1, 11, "R10");
    // page whose first beat arrived while stopped
    setRec(1'b0);
    @(negedge clk); pageBeat = 1'b1; pageEnd = 1'b0;
    @(negedge clk); pageBeat = 1'b0;
    setRec(1'b1);
    @(negedge clk); pageBeat = 1'b1; pageEnd = 1'b1; #1;
    check("R10", {63'd0, wrEn}, 64'd0);
    @(negedge clk); pageBeat = 1'b0; pageEnd = 1'b0;
    check("R10", 64'(lastPage), 64'd11);
    sendPage(1, 64'd2003, 1'b1, 12, "R10");

    // R9 new allocation restart, R11 wrap at top of memory
    setRec(1'b0);
    writeAlloc((1 << PAGE_AW) - 2, 4);
    setRec(1'b1);
    check("R9", 64'(freshPages), 64'd0);
    sendPage(1, 64'd3000, 1'b1, (1 << PAGE_AW) - 2, "R9");
    sendPage(1, 64'd3001, 1'b1, (1 << PAGE_AW) - 1, "R11");
    sendPage(1, 64'd3002, 1'b1, 0, "R11");
    sendPage(1, 64'd3003, 1'b1, 1, "R11");
    check("R11", 64'(lastPage), 64'd1);
    check("R5", 64'(freshPages), 64'd4);
    sendPage(1, 64'd3004, 1'b1, (1 << PAGE_AW) - 2, "R4");

    // R7 zero-page region
    setRec(1'b0);
    writeAlloc(40, 0);
    setRec(1'b1);
    sendPage(2, 64'd4000, 1'b0, 0, "R7");
    check("R7", 64'(freshPages), 64'd0);
    check("R7", 64'(lastPage), 64'((1 << PAGE_AW) - 2));
    check("R7", lastSsn, 64'd3004);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule